// File: doc/BRIEF.md
# Chained Bus Word Cipher with Group Authenticator

This unit protects words passed between caches over a shared snooping bus. Each side holds the same chain value. A sender combines its plaintext word with the chain value by XOR and drives the result onto the bus on the next clock, so the transfer path carries only a single XOR and one register. The encrypted block cipher runs afterwards. The unit hands the word that went onto the bus to an external block-cipher port, and the cipher's answer becomes the new chain value. A receiver does the reverse. It XORs the observed bus word with its chain value to recover the plaintext, then hands the same bus word to the cipher port, so both ends stay in step.

The chain also serves as a running authenticator. After a fixed number of completed transfers, the group is closed. The upper bits of the chain are presented as the group's tag for one cycle and compared with a tag supplied by the partner, and any difference raises a flag. The starting chain value comes from an initial-value register. That register is reset to a parameter value and can be rewritten at any time. Its contents are copied into the chain at reset and on a resynchronise request.

The controller has three states. `ST_IDLE` accepts work. `ST_WAIT` holds the cipher request. `ST_MAC` presents the tag. The transitions are as follows:
- idle→wait on an accepted transfer.
- idle→idle on a resynchronise request or when there is no work.
- wait→wait while the cipher has not answered.
- wait→idle on a cipher answer that does not end a group.
- wait→mac on the answer that completes a group.
- mac→idle unconditionally.

Top module: `bus_chain_crypt`

## Requirements
- R1: When `xfer_ready` is high, `resync` is low and `tx_valid` is high at a clock edge, the transfer is accepted. On the following cycle `bus_out_valid` is high for exactly one cycle and `bus_out_word` equals `tx_data` XOR the chain value. `bus_out_word` keeps its value until the next send.
- R2: When a receive is accepted (`xfer_ready` high, `resync` low, `tx_valid` low, `rx_valid` high), `rx_out_valid` is high for one cycle on the following cycle and `rx_out_data` equals `rx_word` XOR the chain value. A send and a receive offered together are resolved in favour of the send, and the receive waits.
- R3: `xfer_ready` is low from the cycle after an acceptance until the cycle after the cipher answers, and also during the tag cycle. Only one transfer is outstanding at a time.
- R4: While a transfer is pending, `cph_req` stays high with `cph_in` equal to the word placed on the bus (for a receive, the received bus word) until `cph_ack`. The `cph_out` value sampled with `cph_ack` becomes the chain value for the next transfer.
- R5: `cph_ack` while no request is pending has no effect on the chain.
- R6: The `GROUP`-th completed chain update after reset or resynchronisation is followed by one cycle with `mac_valid` high. In that cycle `mac_out` equals the top `MACW` bits of the new chain value. At other times `mac_out` is zero. Counting then restarts.
- R7: `mac_bad` is high exactly when `mac_valid` is high and `mac_out` differs from `mac_in`.
- R8: After reset the chain and the initial-value register both equal `IV_RST`, the group count is zero, `xfer_ready` is high, all valid outputs are low and all word outputs are zero.
- R9: `iv_load` writes `iv_data` into the initial-value register in any state without changing the chain. `resync` sampled while `xfer_ready` is high copies the register's previous contents into the chain, clears the group count and takes priority over a transfer. `resync` in any other state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iv_load | input | 1 | Write strobe for the initial-value register |
| iv_data | input | W | New initial value |
| resync | input | 1 | Copy the initial value into the chain (idle only) |
| tx_valid | input | 1 | Plaintext word offered for sending |
| tx_data | input | W | Plaintext word to send |
| rx_valid | input | 1 | Bus word observed for receiving |
| rx_word | input | W | Bus word from a partner |
| xfer_ready | output | 1 | Unit can take a transfer or resync |
| bus_out_valid | output | 1 | Bus word valid pulse |
| bus_out_word | output | W | Word to drive on the bus |
| rx_out_valid | output | 1 | Recovered plaintext valid pulse |
| rx_out_data | output | W | Recovered plaintext |
| cph_req | output | 1 | Block-cipher request, held until answered |
| cph_in | output | W | Block-cipher input |
| cph_ack | input | 1 | Block-cipher answer strobe |
| cph_out | input | W | Block-cipher result |
| mac_in | input | MACW | Tag supplied by the partner |
| mac_valid | output | 1 | Group tag cycle |
| mac_out | output | MACW | Group tag (upper chain bits) |
| mac_bad | output | 1 | Tag mismatch flag |

## Verification
The bench varies the cipher's answer latency from zero to several cycles. A unit that re-opens `xfer_ready` early or samples `cph_out` off the strobe would chain on a stale value, and every later bus word would diverge. Simultaneous send and receive offers check that the receive is not dropped or decoded with the pre-send chain. A stray cipher strobe while idle and a resynchronise pulse during a pending request must both leave the chain untouched. A miscounted group would put the tag cycle on the wrong transfer. Tags are presented both matching and corrupted, a new initial value is loaded and resynchronised, and a group is broken by resynchronisation to confirm that the count restarts.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_MAC  = 2'd2
    } bcc_state_e;
endpackage

// File: rtl/bcc_iv_reg.sv
module bcc_iv_reg #(
    parameter int          W      = 32,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RST_VAL;
        else if (load)
            q <= din;
    end
endmodule

// File: rtl/bcc_grp_cnt.sv
module bcc_grp_cnt #(
    parameter int GROUP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(GROUP + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(GROUP - 1);

    logic [CW-1:0] cnt;

    assign last = (cnt == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc)
            cnt <= last ? '0 : cnt + 1'b1;
    end

    // R6: the count never leaves the group range
    a_r6_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(GROUP));
endmodule

// File: rtl/bcc_ctrl.sv
module bcc_ctrl
    import bcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_valid,
    input  logic rx_valid,
    input  logic resync,
    input  logic cph_ack,
    input  logic grp_last,
    output logic ready,
    output logic accept_tx,
    output logic accept_rx,
    output logic do_resync,
    output logic chain_upd,
    output logic cph_req,
    output logic mac_valid
);
    bcc_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!resync && (tx_valid || rx_valid))
                    state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (cph_ack)
                    state_nx = grp_last ? ST_MAC : ST_IDLE;
            end
            ST_MAC:  state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ready     = 1'b0;
        accept_tx = 1'b0;
        accept_rx = 1'b0;
        do_resync = 1'b0;
        chain_upd = 1'b0;
        cph_req   = 1'b0;
        mac_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                ready     = 1'b1;
                do_resync = resync;
                accept_tx = !resync && tx_valid;
                accept_rx = !resync && !tx_valid && rx_valid;
            end
            ST_WAIT: begin
                cph_req   = 1'b1;
                chain_upd = cph_ack;
            end
            ST_MAC:  mac_valid = 1'b1;
            default: ;
        endcase
    end

    // R3: no two acceptances back to back
    a_r3_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_tx || accept_rx) |=> !ready);
endmodule

// File: rtl/bus_chain_crypt.sv
module bus_chain_crypt #(
    parameter int           W      = 32,
    parameter int           MACW   = 16,
    parameter int           GROUP  = 4,
    parameter logic [W-1:0] IV_RST = 32'h6A09_E667
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            iv_load,
    input  logic [W-1:0]    iv_data,
    input  logic            resync,
    input  logic            tx_valid,
    input  logic [W-1:0]    tx_data,
    input  logic            rx_valid,
    input  logic [W-1:0]    rx_word,
    output logic            xfer_ready,
    output logic            bus_out_valid,
    output logic [W-1:0]    bus_out_word,
    output logic            rx_out_valid,
    output logic [W-1:0]    rx_out_data,
    output logic            cph_req,
    output logic [W-1:0]    cph_in,
    input  logic            cph_ack,
    input  logic [W-1:0]    cph_out,
    input  logic [MACW-1:0] mac_in,
    output logic            mac_valid,
    output logic [MACW-1:0] mac_out,
    output logic            mac_bad
);
    localparam int TAG_LSB = W - MACW;

    logic         accept_tx, accept_rx, do_resync, chain_upd, grp_last;
    logic [W-1:0] iv_q;
    logic [W-1:0] chain;
    logic [W-1:0] c_reg;

    bcc_iv_reg #(.W(W), .RST_VAL(IV_RST)) u_iv (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (iv_load),
        .din   (iv_data),
        .q     (iv_q)
    );

    bcc_grp_cnt #(.GROUP(GROUP)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (do_resync),
        .inc   (chain_upd),
        .last  (grp_last)
    );

    bcc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_valid  (tx_valid),
        .rx_valid  (rx_valid),
        .resync    (resync),
        .cph_ack   (cph_ack),
        .grp_last  (grp_last),
        .ready     (xfer_ready),
        .accept_tx (accept_tx),
        .accept_rx (accept_rx),
        .do_resync (do_resync),
        .chain_upd (chain_upd),
        .cph_req   (cph_req),
        .mac_valid (mac_valid)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= IV_RST;
        else if (do_resync)
            chain <= iv_q;
        else if (chain_upd)
            chain <= cph_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_reg         <= '0;
            bus_out_valid <= 1'b0;
            bus_out_word  <= '0;
            rx_out_valid  <= 1'b0;
            rx_out_data   <= '0;
        end else begin
            bus_out_valid <= accept_tx;
            rx_out_valid  <= accept_rx;
            if (accept_tx) begin
                c_reg        <= tx_data ^ chain;
                bus_out_word <= tx_data ^ chain;
            end else if (accept_rx) begin
                c_reg       <= rx_word;
                rx_out_data <= rx_word ^ chain;
            end
        end
    end

    assign cph_in  = c_reg;
    assign mac_out = mac_valid ? chain[W-1:TAG_LSB] : '0;
    assign mac_bad = mac_valid && (mac_out != mac_in);

    // R1: an accepted send reaches the bus on the next cycle
    a_r1_send_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ready && !resync && tx_valid) |=> bus_out_valid);

    // R2: a send and a receive never complete together
    a_r2_dir_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_out_valid && rx_out_valid));

    // R4: the cipher request and its operand hold until answered
    a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (cph_req && !cph_ack) |=> (cph_req && $stable(cph_in)));

    // R6: a tag cycle only follows a cipher answer
    a_r6_tag_after_answer: assert property (@(posedge clk) disable iff (!rst_n)
        mac_valid |-> $past(cph_ack));

    // R3: the unit is never ready while the cipher is busy
    a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cph_req |-> !xfer_ready);
endmodule

// File: tb/sim_bus_chain_crypt.sv
module sim_bus_chain_crypt;
    localparam int           W      = 32;
    localparam int           MACW   = 16;
    localparam int           GROUP  = 4;
    localparam logic [W-1:0] IV_RST = 32'h6A09_E667;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            iv_load = 1'b0;
    logic [W-1:0]    iv_data = '0;
    logic            resync = 1'b0;
    logic            tx_valid = 1'b0;
    logic [W-1:0]    tx_data = '0;
    logic            rx_valid = 1'b0;
    logic [W-1:0]    rx_word = '0;
    logic            xfer_ready;
    logic            bus_out_valid;
    logic [W-1:0]    bus_out_word;
    logic            rx_out_valid;
    logic [W-1:0]    rx_out_data;
    logic            cph_req;
    logic [W-1:0]    cph_in;
    logic            cph_ack = 1'b0;
    logic [W-1:0]    cph_out = '0;
    logic [MACW-1:0] mac_in = '0;
    logic            mac_valid;
    logic [MACW-1:0] mac_out;
    logic            mac_bad;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int lat_sel = 0;
    int wait_left = 0;
    bit stray = 1'b0;
    bit mac_corrupt = 1'b0;
    bit done = 1'b0;

    // reference model state
    int           m_phase = 0;
    int           m_cnt = 0;
    logic [W-1:0] m_chain = IV_RST;
    logic [W-1:0] m_iv = IV_RST;
    logic [W-1:0] m_c = '0;
    logic         mb_v = 1'b0;
    logic [W-1:0] mb_w = '0;
    logic         mr_v = 1'b0;
    logic [W-1:0] mr_d = '0;

    always #10 clk = ~clk;

    bus_chain_crypt #(.W(W), .MACW(MACW), .GROUP(GROUP), .IV_RST(IV_RST)) u0 (
        .clk(clk), .rst_n(rst_n), .iv_load(iv_load), .iv_data(iv_data),
        .resync(resync), .tx_valid(tx_valid), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_word(rx_word), .xfer_ready(xfer_ready),
        .bus_out_valid(bus_out_valid), .bus_out_word(bus_out_word),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
        .cph_req(cph_req), .cph_in(cph_in), .cph_ack(cph_ack), .cph_out(cph_out),
        .mac_in(mac_in), .mac_valid(mac_valid), .mac_out(mac_out), .mac_bad(mac_bad)
    );

    function automatic logic [W-1:0] toy_cipher(input logic [W-1:0] x);
        return {x[26:0], x[31:27]} ^ {x[15:0], x[31:16]} ^ 32'h5A3C_96E1;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_chain = IV_RST; m_iv = IV_RST; m_c = '0;
            mb_v = 1'b0; mb_w = '0; mr_v = 1'b0; mr_d = '0;
        end else begin
            mb_v = 1'b0;
            mr_v = 1'b0;
            case (m_phase)
                0: begin
                    if (resync) begin
                        m_chain = m_iv;
                        m_cnt = 0;
                    end else if (tx_valid) begin
                        m_c = tx_data ^ m_chain; mb_w = m_c; mb_v = 1'b1; m_phase = 1;
                    end else if (rx_valid) begin
                        m_c = rx_word; mr_d = rx_word ^ m_chain; mr_v = 1'b1; m_phase = 1;
                    end
                end
                1: begin
                    if (cph_ack) begin
                        m_chain = cph_out;
                        m_cnt++;
                        if (m_cnt == GROUP) begin
                            m_cnt = 0;
                            m_phase = 2;
                        end else begin
                            m_phase = 0;
                        end
                    end
                end
                default: m_phase = 0;
            endcase
            if (iv_load) m_iv = iv_data;
        end
    end

    // external cipher model and partner tag
    always @(negedge clk) begin
        mac_in = m_chain[W-1 -: MACW] ^ {{(MACW-1){1'b0}}, mac_corrupt};
        if (cph_ack) begin
            cph_ack = 1'b0;
        end else if (stray && !cph_req) begin
            cph_ack = 1'b1;
            cph_out = 32'hDEAD_BEEF;
            stray = 1'b0;
        end else if (cph_req) begin
            if (wait_left <= 0) begin
                cph_ack = 1'b1;
                cph_out = toy_cipher(cph_in);
                wait_left = lat_sel;
            end else begin
                wait_left--;
            end
        end else begin
            wait_left = lat_sel;
        end
    end

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        #1;
        if (!done) begin
            check("R3", "xfer_ready", 64'(xfer_ready), 64'(m_phase == 0));
            check("R1", "bus_out_valid", 64'(bus_out_valid), 64'(mb_v));
            check("R1", "bus_out_word", 64'(bus_out_word), 64'(mb_w));
            check("R2", "rx_out_valid", 64'(rx_out_valid), 64'(mr_v));
            check("R2", "rx_out_data", 64'(rx_out_data), 64'(mr_d));
            check("R4", "cph_req", 64'(cph_req), 64'(m_phase == 1));
            check("R4", "cph_in", 64'(cph_in), 64'(m_c));
            check("R6", "mac_valid", 64'(mac_valid), 64'(m_phase == 2));
            check("R6", "mac_out", 64'(mac_out),
                  (m_phase == 2) ? 64'(m_chain[W-1 -: MACW]) : 64'd0);
            check("R7", "mac_bad", 64'(mac_bad), 64'((m_phase == 2) && mac_corrupt));
        end
    end

    task automatic wait_ready();
        while (xfer_ready !== 1'b1) @(negedge clk);
    endtask

    task automatic send(input logic [W-1:0] d);
        wait_ready();
        tx_valid = 1'b1; tx_data = d;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic recv(input logic [W-1:0] d);
        wait_ready();
        rx_valid = 1'b1; rx_word = d;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        // R8: reset state at the ports
        check("R8", "reset ready", 64'(xfer_ready), 64'd1);
        check("R8", "reset bus_out_valid", 64'(bus_out_valid), 64'd0);
        check("R8", "reset mac_valid", 64'(mac_valid), 64'd0);
        check("R8", "reset cph_in", 64'(cph_in), 64'd0);
        rst_n = 1'b1;
        idle(1);
        // R1 R4 R6: one group of sends, latency 0, matching tag (R7)
        lat_sel = 0;
        send(32'h0000_0000);
        send(32'h1234_5678);
        send(32'hFFFF_FFFF);
        send(32'hA5A5_5A5A);
        wait_ready();
        // R2: receives with longer latency, corrupted tag (R7)
        lat_sel = 3;
        mac_corrupt = 1'b1;
        recv(32'h0F0F_F0F0);
        recv(32'h8000_0001);
        lat_sel = 1;
        send(32'h7777_1111);
        recv(32'hCAFE_0123);
        wait_ready();
        idle(2);
        mac_corrupt = 1'b0;
        // R5: stray cipher strobe while idle
        stray = 1'b1;
        idle(3);
        send(32'h0BAD_F00D);
        // R2 R3: send and receive offered together, send wins
        wait_ready();
        tx_valid = 1'b1; tx_data = 32'h1111_2222;
        rx_valid = 1'b1; rx_word = 32'h3333_4444;
        @(negedge clk);
        tx_valid = 1'b0;
        wait_ready();
        @(negedge clk);
        rx_valid = 1'b0;
        // R9: resync during a pending request is ignored
        lat_sel = 2;
        wait_ready();
        tx_valid = 1'b1; tx_data = 32'h5555_AAAA;
        @(negedge clk);
        tx_valid = 1'b0;
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        // R9: load a new value, resync with priority over a send
        wait_ready();
        iv_load = 1'b1; iv_data = 32'h0123_4567;
        @(negedge clk);
        iv_load = 1'b0;
        wait_ready();
        resync = 1'b1; tx_valid = 1'b1; tx_data = 32'h9999_0000;
        iv_load = 1'b1; iv_data = 32'hFEDC_BA98;
        @(negedge clk);
        resync = 1'b0; iv_load = 1'b0;
        @(negedge clk);
        tx_valid = 1'b0;
        // R6: full group counted from resync
        lat_sel = 0;
        for (int i = 0; i < GROUP + 1; i++) send(32'h1000_0000 + 32'(i));
        wait_ready();
        resync = 1'b1;
        @(negedge clk);
        resync = 1'b0;
        for (int i = 0; i < GROUP; i++) recv(32'h2000_0000 ^ 32'(i * 7));
        idle(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule